// File: doc/BRIEF.md
# Disk Controller Interrupt Source Flops

This block decides when a multi-drive disk controller raises its interrupt request. The request is not a simple gate of the controller done flag and the enable bit. Three separate flops hold the reasons for an interrupt: a controller-done flop, a drive-attention flop and an error flop. Each flop is set or loaded by a specific event. The request line is the interrupt-enable bit ANDed with the OR of the three flops.

The surrounding controller supplies three kinds of input. The first is its control register write strobe, which carries the interrupt-enable, done and GO bits being written. The second is its current and previous done flag, together with the present attention bit of every drive. The third is event inputs: a per-drive attention-raise vector (attach or removal of a drive), an error event, a controller clear and the bus interrupt acknowledge.

The block drives three outputs. It drives the request line. It drives the drive-interrupt status bit that the control register shows on a read. It drives the device vector during an acknowledge.

Top module: `dkirq_top`

## Requirements
- R1: While reset is held and on the first cycle after it, intReq, diStatus and vecOut are all 0.
- R2: A control write with wrIe=1, wrDone=1 and wrGo=0 sets the controller-done flop. With ieBit=1, intReq is 1 from the next cycle on.
- R3: On a done rising edge (doneNow=1, donePrev=0), the controller-done flop takes the value of ieBit. If ieBit was 0 at the edge, a later ieBit=1 alone raises no request.
- R4: On a done rising edge, the drive-attention flop is set when any bit of atnVec is 1.
- R5: While done stays 1, the drive-attention flop is set when atnRaise has a 1 on a drive whose atnVec bit is 0. A raise on a drive whose atnVec bit is already 1 has no effect.
- R6: In any cycle where doneNow is 0, the drive-attention flop is cleared on the next edge, even if attention events arrive.
- R7: An errEvt pulse sets the error flop.
- R8: intReq equals ieBit AND (controller-done OR drive-attention OR error flop). It follows ieBit in the same cycle.
- R9: intAck clears all three flops. vecOut equals the VECTOR parameter (default 8'h88) while intAck is 1, and 0 otherwise.
- R10: ctlClear, or a control write with wrGo=1, clears all three flops. A clear wins over any set event in the same cycle.
- R11: diStatus is the live value of the drive-attention flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStrobe | input | 1 | Control register write strobe |
| wrIe | input | 1 | Interrupt-enable bit of the written data |
| wrDone | input | 1 | Done bit of the written data |
| wrGo | input | 1 | GO bit of the written data (command accepted) |
| ieBit | input | 1 | Current interrupt-enable register bit |
| doneNow | input | 1 | Current controller done flag |
| donePrev | input | 1 | Done flag of the previous cycle |
| atnVec | input | NUM_DRIVES | Present attention bit per drive |
| atnRaise | input | NUM_DRIVES | Per-drive attention raise (attach or removal) |
| errEvt | input | 1 | Pulse: the combined error bit is being set |
| ctlClear | input | 1 | Controller clear |
| intAck | input | 1 | Bus interrupt acknowledge |
| intReq | output | 1 | Interrupt request |
| diStatus | output | 1 | Drive-interrupt bit for control register reads |
| vecOut | output | VEC_W | Device vector during acknowledge, else 0 |

## Verification
The clear path and the set paths of the flops can both fire on the same clock edge. Two cases matter: an acknowledge arriving together with a new error event, and a controller clear arriving together with a write that sets the enable and done bits. The bench drives both inputs in the same cycle. It then checks that the request is low on the next cycle, which shows that the clear won. It also checks the done rising edge against an attention raise, with done held high and with done held low.

// File: rtl/dkirq_pkg.sv
package dkirq_pkg;
  // Strobes from control to the flop datapath
  typedef struct packed {
    logic clrAll;     // clear every source flop
    logic ciSet;      // register write with enable and done
    logic ciLoad;     // done rising edge: load CI
    logic ciLoadVal;  // value loaded into CI
    logic diLoad;     // done rising edge: load DI
    logic diLoadVal;  // value loaded into DI
    logic diSet;      // new attention while done is high
    logic diClr;      // done low: hold DI clear
    logic eiSet;      // error event
  } irqStrobe_t;
endpackage

// File: rtl/dkirq_ctl.sv
module dkirq_ctl
  import dkirq_pkg::*;
#(
  parameter int NUM_DRIVES = 8
) (
  input  logic                  wrStrobe,
  input  logic                  wrIe,
  input  logic                  wrDone,
  input  logic                  wrGo,
  input  logic                  ieBit,
  input  logic                  doneNow,
  input  logic                  donePrev,
  input  logic [NUM_DRIVES-1:0] atnVec,
  input  logic [NUM_DRIVES-1:0] atnRaise,
  input  logic                  errEvt,
  input  logic                  ctlClear,
  input  logic                  intAck,
  output irqStrobe_t            stb
);
  logic doneRise;
  logic [NUM_DRIVES-1:0] freshAtn;
  logic atnEvent;

  // An attach or removal only counts when that drive had no attention yet
  genvar g;
  generate
    for (g = 0; g < NUM_DRIVES; g++) begin : gFresh
      assign freshAtn[g] = atnRaise[g] & ~atnVec[g];
    end
  endgenerate

  assign atnEvent = |freshAtn;
  assign doneRise = doneNow & ~donePrev;

  always_comb begin
    stb.clrAll    = ctlClear | intAck | (wrStrobe & wrGo);
    stb.ciSet     = wrStrobe & wrIe & wrDone;
    stb.ciLoad    = doneRise;
    stb.ciLoadVal = ieBit;
    stb.diLoad    = doneRise;
    stb.diLoadVal = (|atnVec) | atnEvent;
    stb.diSet     = doneNow & atnEvent;
    stb.diClr     = ~doneNow;
    stb.eiSet     = errEvt;
  end
endmodule

// File: rtl/dkirq_dp.sv
module dkirq_dp
  import dkirq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  irqStrobe_t stb,
  input  logic       ieBit,
  output logic       ciFlop,
  output logic       diFlop,
  output logic       eiFlop,
  output logic       intReq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ciFlop <= 1'b0;
      diFlop <= 1'b0;
      eiFlop <= 1'b0;
    end else if (stb.clrAll) begin
      ciFlop <= 1'b0;
      diFlop <= 1'b0;
      eiFlop <= 1'b0;
    end else begin
      ciFlop <= stb.ciSet | (stb.ciLoad ? stb.ciLoadVal : ciFlop);
      if (stb.diClr)       diFlop <= 1'b0;
      else if (stb.diLoad) diFlop <= stb.diLoadVal;
      else                 diFlop <= diFlop | stb.diSet;
      eiFlop <= eiFlop | stb.eiSet;
    end
  end

  assign intReq = ieBit & (ciFlop | diFlop | eiFlop);
endmodule

// File: rtl/dkirq_top.sv
module dkirq_top
  import dkirq_pkg::*;
#(
  parameter int NUM_DRIVES = 8,
  parameter int VEC_W      = 8,
  parameter logic [VEC_W-1:0] VECTOR = 8'h88
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrStrobe,
  input  logic                  wrIe,
  input  logic                  wrDone,
  input  logic                  wrGo,
  input  logic                  ieBit,
  input  logic                  doneNow,
  input  logic                  donePrev,
  input  logic [NUM_DRIVES-1:0] atnVec,
  input  logic [NUM_DRIVES-1:0] atnRaise,
  input  logic                  errEvt,
  input  logic                  ctlClear,
  input  logic                  intAck,
  output logic                  intReq,
  output logic                  diStatus,
  output logic [VEC_W-1:0]      vecOut
);
  localparam logic [VEC_W-1:0] NO_VEC = '0;

  irqStrobe_t stb;
  logic ciFlop, diFlop, eiFlop;

  dkirq_ctl #(.NUM_DRIVES(NUM_DRIVES)) uCtl (
    .wrStrobe(wrStrobe), .wrIe(wrIe), .wrDone(wrDone), .wrGo(wrGo),
    .ieBit(ieBit), .doneNow(doneNow), .donePrev(donePrev),
    .atnVec(atnVec), .atnRaise(atnRaise), .errEvt(errEvt),
    .ctlClear(ctlClear), .intAck(intAck), .stb(stb)
  );

  dkirq_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .ieBit(ieBit),
    .ciFlop(ciFlop), .diFlop(diFlop), .eiFlop(eiFlop), .intReq(intReq)
  );

  assign diStatus = diFlop;
  assign vecOut   = intAck ? VECTOR : NO_VEC;
endmodule

// File: rtl/dkirq_chk.sv
module dkirq_chk #(
  parameter int NUM_DRIVES = 8,
  parameter int VEC_W      = 8,
  parameter logic [VEC_W-1:0] VECTOR = 8'h88
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrStrobe,
  input logic                  wrGo,
  input logic                  ieBit,
  input logic                  doneNow,
  input logic                  donePrev,
  input logic [NUM_DRIVES-1:0] atnVec,
  input logic                  errEvt,
  input logic                  ctlClear,
  input logic                  intAck,
  input logic                  intReq,
  input logic                  diStatus,
  input logic [VEC_W-1:0]      vecOut
);
  logic anyClr;
  assign anyClr = ctlClear | intAck | (wrStrobe & wrGo);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> (!intReq && !diStatus));

  a_r9_vector: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> (vecOut == VECTOR));

  a_r9_no_vector: assert property (@(posedge clk) disable iff (!rstN)
    !intAck |-> (vecOut == '0));

  a_r6_di_low: assert property (@(posedge clk) disable iff (!rstN)
    !doneNow |=> !diStatus);

  a_r8_masked: assert property (@(posedge clk) disable iff (!rstN)
    !ieBit |-> !intReq);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctlClear |=> (!intReq && !diStatus));

  a_r7_error_sets: assert property (@(posedge clk) disable iff (!rstN)
    (errEvt && !anyClr) ##1 ieBit |-> intReq);

  a_r4_rise_atn: assert property (@(posedge clk) disable iff (!rstN)
    (doneNow && !donePrev && (|atnVec) && !anyClr) |=> diStatus);
endmodule

bind dkirq_top dkirq_chk #(.NUM_DRIVES(NUM_DRIVES), .VEC_W(VEC_W), .VECTOR(VECTOR)) uChk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrGo(wrGo), .ieBit(ieBit),
  .doneNow(doneNow), .donePrev(donePrev), .atnVec(atnVec), .errEvt(errEvt),
  .ctlClear(ctlClear), .intAck(intAck), .intReq(intReq), .diStatus(diStatus),
  .vecOut(vecOut)
);

// File: tb/tb_dkirq_top.sv
module tb_dkirq_top;
  localparam int ND = 8;
  localparam int VW = 8;
  localparam logic [VW-1:0] VEC = 8'h88;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStrobe = 0, wrIe = 0, wrDone = 0, wrGo = 0, ieBit = 0;
  logic doneNow = 0, donePrev = 0, errEvt = 0, ctlClear = 0, intAck = 0;
  logic [ND-1:0] atnVec = '0, atnRaise = '0;
  logic intReq, diStatus;
  logic [VW-1:0] vecOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dkirq_top #(.NUM_DRIVES(ND), .VEC_W(VW), .VECTOR(VEC)) dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrIe(wrIe), .wrDone(wrDone),
    .wrGo(wrGo), .ieBit(ieBit), .doneNow(doneNow), .donePrev(donePrev),
    .atnVec(atnVec), .atnRaise(atnRaise), .errEvt(errEvt), .ctlClear(ctlClear),
    .intAck(intAck), .intReq(intReq), .diStatus(diStatus), .vecOut(vecOut)
  );

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one edge, settle after it
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic clearAll();
    ctlClear = 1; tick(); ctlClear = 0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 intReq in reset", intReq, 0);
    check("R1 diStatus in reset", diStatus, 0);
    check("R1 vecOut in reset", vecOut, 0);
    tick(); tick();
    rstN = 1;
    tick();
    check("R1 intReq after reset", intReq, 0);
  endtask

  task automatic t_ciWrite();
    ieBit = 1; doneNow = 1; donePrev = 1;
    wrStrobe = 1; wrIe = 1; wrDone = 1; tick();
    wrStrobe = 0; wrIe = 0; wrDone = 0;
    check("R2 write IE+DONE sets request", intReq, 1);
    check("R11 DI clear after CI write", diStatus, 0);
    ieBit = 0; #1;
    check("R8 enable low masks", intReq, 0);
    ieBit = 1; #1;
    check("R8 enable high unmasks", intReq, 1);
    intAck = 1; #1;
    check("R9 vector during ack", vecOut, VEC);
    tick(); intAck = 0; #1;
    check("R9 ack clears request", intReq, 0);
    check("R9 vector after ack", vecOut, 0);
  endtask

  task automatic t_riseLoadsCi();
    doneNow = 0; donePrev = 0; ieBit = 0; tick();
    doneNow = 1; tick();
    donePrev = 1; ieBit = 1; #1;
    check("R3 rise with IE=0 leaves CI clear", intReq, 0);
    doneNow = 0; tick(); donePrev = 0; tick();
    doneNow = 1; tick();
    donePrev = 1;
    check("R3 rise with IE=1 sets CI", intReq, 1);
    clearAll();
  endtask

  task automatic t_riseAtn();
    ieBit = 0; doneNow = 0; donePrev = 0; atnVec = 8'h10; tick();
    doneNow = 1; tick(); donePrev = 1;
    check("R4 rise with attention sets DI", diStatus, 1);
    check("R8 masked with DI set", intReq, 0);
    doneNow = 0; tick(); donePrev = 0;
    check("R6 done low clears DI", diStatus, 0);
    atnVec = 0;
  endtask

  task automatic t_atnWhileDone();
    doneNow = 1; donePrev = 1; ieBit = 1; clearAll();
    atnVec = 8'h01; atnRaise = 8'h01; tick(); atnRaise = 0;
    check("R5 raise on drive already attentive ignored", diStatus, 0);
    check("R5 no request from repeated attention", intReq, 0);
    atnRaise = 8'h04; tick(); atnRaise = 0;
    check("R5 fresh attention sets DI", diStatus, 1);
    check("R5 fresh attention raises request", intReq, 1);
    clearAll();
    check("R10 controller clear drops request", intReq, 0);
    check("R10 controller clear drops DI", diStatus, 0);
    atnVec = 0;
  endtask

  task automatic t_atnDoneLow();
    doneNow = 0; donePrev = 0; ieBit = 1;
    atnRaise = 8'h02; tick(); atnRaise = 0;
    check("R6 attention with done low ignored", diStatus, 0);
    check("R6 no request with done low", intReq, 0);
  endtask

  task automatic t_errAndGo();
    ieBit = 1; doneNow = 0;
    errEvt = 1; tick(); errEvt = 0;
    check("R7 error event raises request", intReq, 1);
    wrStrobe = 1; wrGo = 1; tick(); wrStrobe = 0; wrGo = 0;
    check("R10 GO write clears request", intReq, 0);
  endtask

  task automatic t_collide();
    ieBit = 1;
    errEvt = 1; intAck = 1; tick(); errEvt = 0; intAck = 0;
    check("R9 ack wins over same-cycle error", intReq, 0);
    doneNow = 1; donePrev = 1;
    ctlClear = 1; wrStrobe = 1; wrIe = 1; wrDone = 1; tick();
    ctlClear = 0; wrStrobe = 0; wrIe = 0; wrDone = 0;
    check("R10 clear wins over same-cycle CI write", intReq, 0);
    wrStrobe = 1; wrIe = 1; wrDone = 1; wrGo = 1; tick();
    wrStrobe = 0; wrIe = 0; wrDone = 0; wrGo = 0;
    check("R10 GO in same write wins over CI set", intReq, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_ciWrite();
    t_riseLoadsCi();
    t_riseAtn();
    t_atnWhileDone();
    t_atnDoneLow();
    t_errAndGo();
    t_collide();
    finish();
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end
endmodule